// File: doc/BRIEF.md
# Dual-Slice Interrupt Pending Controller

This block gathers interrupt requests for a node whose two processor slices share one set of pending state. It keeps two pending words. Every level has a number: word 0 holds levels 0 to WORD_W-1, and word 1 holds the levels above. Device messages, inter-processor requests and software commands set pending bits by level number. Software clears a bit by level number.

Each slice owns a private mask for each word. For each slice and each word, the block ANDs the pending word with that slice's mask. It raises one registered interrupt line when the result is non-zero, and it reports the index of the highest set bit of that result. The word 0 result drives the slice's processor interrupt line 2 and the word 1 result drives line 3.

The lowest SYS_RSV bits of word 0 belong to system sources. Inside that region, four fixed levels carry the inter-processor requests: reschedule for slice A and for slice B, and call for slice A and for slice B. A slice's level is the A level plus the slice index (A = 0, B = 1).

Top module: `irqp_hub`

## Requirements
- R1: After reset, all pending bits and all masks are zero, every interrupt line is low, every reported level is 0 and the read data is 0.
- R2: The register bus maps address 2 to the slice A mask of word 0, 3 to the slice A mask of word 1, 4 to the slice B mask of word 0 and 5 to the slice B mask of word 1. A write with bus_we_i high loads the full word. A mask holds its value when it is not written. bus_rdata_o shows the register addressed one cycle earlier.
- R3: A write to address 6 sets the pending bit whose level number is in bus_wdata_i[LVL_W-1:0]. A write to address 7 clears only that bit. The level encoding is word = level / WORD_W and bit = level % WORD_W.
- R4: A cycle with msg_vld_i high sets the pending bit for level msg_lvl_i. A message whose level lies in word 0 below SYS_RSV changes nothing.
- R5: Bit s of ipi_rsch_i sets level RSCH_BASE+s, and bit s of ipi_call_i sets level CALL_BASE+s (slice A = bit 0, slice B = bit 1).
- R6: When a set and a clear reach the same level in the same cycle, the bit is set afterwards.
- R7: irq_ln2_o[s] and irq_ln3_o[s] are high exactly when pending word 0 (or word 1) ANDed with slice s's mask for that word was non-zero in the previous cycle. A line drops in the cycle after that value becomes zero.
- R8: lvl_ln2_o[s] and lvl_ln3_o[s] give the index of the most significant bit of that masked value, taken one cycle earlier. Each reads 0 while its line is low.
- R9: The two slices share the pending words, but a slice's mask and outputs never depend on the other slice's mask. Word 0 never affects line 3, and word 1 never affects line 2.
- R10: Reads of address 0 return pending word 0 and reads of address 1 return pending word 1. Writes to those two addresses are ignored. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | WORD_W | Write data, or a level number for the set and clear commands |
| bus_rdata_o | output | WORD_W | Registered read data |
| msg_vld_i | input | 1 | Incoming interrupt message valid |
| msg_lvl_i | input | LVL_W | Level carried by the message |
| ipi_rsch_i | input | 2 | Reschedule request per target slice |
| ipi_call_i | input | 2 | Call request per target slice |
| irq_ln2_o | output | 2 | Per slice: word 0 masked pending is non-zero |
| irq_ln3_o | output | 2 | Per slice: word 1 masked pending is non-zero |
| lvl_ln2_o | output | 2 x IDX_W | Per slice: highest active bit of word 0 |
| lvl_ln3_o | output | 2 x IDX_W | Per slice: highest active bit of word 1 |

## Verification
The bench builds the block with WORD_W = 8, SYS_RSV = 6, RSCH_BASE = 2 and CALL_BASE = 4, which gives 16 levels and 3-bit level indices. At that size the bench visits every level with message, set and clear commands, and it drives all 256 mask patterns of word 0 against a full pending word. Slice B gets the inverse of slice A's mask, so the check covers both the priority encoder and the independence of the slices. Word 1 is filled and drained one bit at a time under two different masks. This shows the one-cycle drop of an interrupt line and the set-over-clear rule on a device level.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
   localparam int NSLC  = 2;
   localparam int NWORD = 2;

   typedef enum logic [2:0] {
      RA_PEND0 = 3'd0,
      RA_PEND1 = 3'd1,
      RA_MSKA0 = 3'd2,
      RA_MSKA1 = 3'd3,
      RA_MSKB0 = 3'd4,
      RA_MSKB1 = 3'd5,
      RA_SET   = 3'd6,
      RA_CLR   = 3'd7
   } irqp_addr_e;
endpackage

// File: rtl/irqp_msb.sv
module irqp_msb #(
   parameter int W = 32,
   localparam int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = |vec_i;
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irqp_store.sv
module irqp_store #(
   parameter int WORD_W    = 32,
   parameter int SYS_RSV   = 6,
   parameter int RSCH_BASE = 2,
   parameter int CALL_BASE = 4,
   localparam int NLVL  = 2 * WORD_W,
   localparam int LVL_W = $clog2(NLVL)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   bset_vld_i,
   input  logic [LVL_W-1:0]       bset_lvl_i,
   input  logic                   bclr_vld_i,
   input  logic [LVL_W-1:0]       bclr_lvl_i,
   input  logic                   msg_vld_i,
   input  logic [LVL_W-1:0]       msg_lvl_i,
   input  logic [1:0]             ipi_rsch_i,
   input  logic [1:0]             ipi_call_i,
   output logic [1:0][WORD_W-1:0] pend_o
);
   logic [NLVL-1:0] set_vec, clr_vec, pend_q;

   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      localparam logic [LVL_W-1:0] LV = LVL_W'(l);
      logic ipi_hit;
      if (l == RSCH_BASE) begin : g_ra
         assign ipi_hit = ipi_rsch_i[0];
      end else if (l == RSCH_BASE + 1) begin : g_rb
         assign ipi_hit = ipi_rsch_i[1];
      end else if (l == CALL_BASE) begin : g_ca
         assign ipi_hit = ipi_call_i[0];
      end else if (l == CALL_BASE + 1) begin : g_cb
         assign ipi_hit = ipi_call_i[1];
      end else begin : g_none
         assign ipi_hit = 1'b0;
      end

      if (l < SYS_RSV) begin : g_sys
         assign set_vec[l] = (bset_vld_i && bset_lvl_i == LV) || ipi_hit;
      end else begin : g_dev
         assign set_vec[l] = (bset_vld_i && bset_lvl_i == LV)
                          || (msg_vld_i && msg_lvl_i == LV) || ipi_hit;
      end
      assign clr_vec[l] = bclr_vld_i && bclr_lvl_i == LV;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/irqp_slice.sv
module irqp_slice #(
   parameter int WORD_W = 32,
   localparam int IDX_W = $clog2(WORD_W)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [1:0]             mask_we_i,
   input  logic [WORD_W-1:0]      wdata_i,
   input  logic [1:0][WORD_W-1:0] pend_i,
   output logic [1:0][WORD_W-1:0] mask_o,
   output logic [1:0]             irq_o,
   output logic [1:0][IDX_W-1:0]  lvl_o
);
   for (genvar w = 0; w < 2; w++) begin : g_word
      logic [WORD_W-1:0] mask_q, eff;
      logic              any;
      logic [IDX_W-1:0]  idx;
      logic              irq_q;
      logic [IDX_W-1:0]  lvl_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)           mask_q <= '0;
         else if (mask_we_i[w]) mask_q <= wdata_i;
      end

      assign eff = pend_i[w] & mask_q;

      irqp_msb #(.W(WORD_W)) i_msb (.vec_i(eff), .any_o(any), .idx_o(idx));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            irq_q <= 1'b0;
            lvl_q <= '0;
         end else begin
            irq_q <= any;
            lvl_q <= idx;
         end
      end

      assign mask_o[w] = mask_q;
      assign irq_o[w]  = irq_q;
      assign lvl_o[w]  = lvl_q;
   end
endmodule

// File: rtl/irqp_hub.sv
module irqp_hub
   import irqp_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int SYS_RSV   = 6,
   parameter int RSCH_BASE = 2,
   parameter int CALL_BASE = 4,
   localparam int LVL_W = $clog2(2 * WORD_W),
   localparam int IDX_W = $clog2(WORD_W)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  bus_we_i,
   input  logic [2:0]            bus_addr_i,
   input  logic [WORD_W-1:0]     bus_wdata_i,
   output logic [WORD_W-1:0]     bus_rdata_o,
   input  logic                  msg_vld_i,
   input  logic [LVL_W-1:0]      msg_lvl_i,
   input  logic [1:0]            ipi_rsch_i,
   input  logic [1:0]            ipi_call_i,
   output logic [1:0]            irq_ln2_o,
   output logic [1:0]            irq_ln3_o,
   output logic [1:0][IDX_W-1:0] lvl_ln2_o,
   output logic [1:0][IDX_W-1:0] lvl_ln3_o
);
   if (WORD_W < 8 || (1 << IDX_W) != WORD_W) begin : g_bad_width
      $error("WORD_W must be a power of two and at least 8");
   end
   if (SYS_RSV > WORD_W) begin : g_bad_rsv
      $error("SYS_RSV must fit in word 0");
   end
   if (RSCH_BASE + 1 >= SYS_RSV || CALL_BASE + 1 >= SYS_RSV) begin : g_bad_ipi
      $error("inter-processor levels must lie inside the system region");
   end
   if (!(RSCH_BASE + 1 < CALL_BASE || CALL_BASE + 1 < RSCH_BASE)) begin : g_bad_ovl
      $error("reschedule and call levels overlap");
   end

   logic [1:0][WORD_W-1:0]      pend_w;
   logic [1:0][1:0][WORD_W-1:0] mask_all;
   logic [WORD_W-1:0]           rdata_q;
   logic                        bset_vld, bclr_vld;

   assign bset_vld = bus_we_i && (irqp_addr_e'(bus_addr_i) == RA_SET);
   assign bclr_vld = bus_we_i && (irqp_addr_e'(bus_addr_i) == RA_CLR);

   irqp_store #(
      .WORD_W(WORD_W), .SYS_RSV(SYS_RSV),
      .RSCH_BASE(RSCH_BASE), .CALL_BASE(CALL_BASE)
   ) i_store (
      .clk_i, .rst_ni,
      .bset_vld_i(bset_vld), .bset_lvl_i(bus_wdata_i[LVL_W-1:0]),
      .bclr_vld_i(bclr_vld), .bclr_lvl_i(bus_wdata_i[LVL_W-1:0]),
      .msg_vld_i, .msg_lvl_i, .ipi_rsch_i, .ipi_call_i,
      .pend_o(pend_w)
   );

   for (genvar s = 0; s < NSLC; s++) begin : g_slc
      logic [1:0]            mwe;
      logic [1:0]            s_irq;
      logic [1:0][IDX_W-1:0] s_lvl;

      for (genvar w = 0; w < NWORD; w++) begin : g_we
         assign mwe[w] = bus_we_i && (bus_addr_i == 3'(2 + 2 * s + w));
      end

      irqp_slice #(.WORD_W(WORD_W)) i_slice (
         .clk_i, .rst_ni,
         .mask_we_i(mwe), .wdata_i(bus_wdata_i), .pend_i(pend_w),
         .mask_o(mask_all[s]), .irq_o(s_irq), .lvl_o(s_lvl)
      );

      assign irq_ln2_o[s] = s_irq[0];
      assign irq_ln3_o[s] = s_irq[1];
      assign lvl_ln2_o[s] = s_lvl[0];
      assign lvl_ln3_o[s] = s_lvl[1];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_q <= '0;
      else begin
         unique case (irqp_addr_e'(bus_addr_i))
            RA_PEND0: rdata_q <= pend_w[0];
            RA_PEND1: rdata_q <= pend_w[1];
            RA_MSKA0: rdata_q <= mask_all[0][0];
            RA_MSKA1: rdata_q <= mask_all[0][1];
            RA_MSKB0: rdata_q <= mask_all[1][0];
            RA_MSKB1: rdata_q <= mask_all[1][1];
            default:  rdata_q <= '0;
         endcase
      end
   end

   assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/irqp_hub_chk.sv
module irqp_hub_chk #(
   parameter int WORD_W  = 32,
   parameter int SYS_RSV = 6,
   localparam int LVL_W = $clog2(2 * WORD_W),
   localparam int IDX_W = $clog2(WORD_W)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_we,
   input logic [2:0]                  bus_addr,
   input logic [WORD_W-1:0]           bus_wdata,
   input logic                        msg_vld,
   input logic [LVL_W-1:0]            msg_lvl,
   input logic [1:0]                  ipi_rsch,
   input logic [1:0]                  ipi_call,
   input logic [2*WORD_W-1:0]         pend_flat,
   input logic [1:0][1:0][WORD_W-1:0] mask_all,
   input logic [1:0]                  irq2,
   input logic [1:0]                  irq3,
   input logic [1:0][IDX_W-1:0]       lvl2,
   input logic [1:0][IDX_W-1:0]       lvl3
);
   // R2
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(mask_all));

   // R3
   clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 3'd7 && !msg_vld && ipi_rsch == 2'b00 && ipi_call == 2'b00)
      |=> !pend_flat[$past(bus_wdata[LVL_W-1:0])]);

   // R4
   sys_msg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_vld && msg_lvl < LVL_W'(SYS_RSV) && !bus_we && ipi_rsch == 2'b00 && ipi_call == 2'b00)
      |=> $stable(pend_flat));

   // R6
   set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_vld && msg_lvl >= LVL_W'(SYS_RSV) && bus_we && bus_addr == 3'd7
       && bus_wdata[LVL_W-1:0] == msg_lvl)
      |=> pend_flat[$past(msg_lvl)]);

   for (genvar s = 0; s < 2; s++) begin : g_s
      // R8
      idle_lvl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !irq2[s] |-> lvl2[s] == '0);
      // R8
      idle_lvl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !irq3[s] |-> lvl3[s] == '0);
      // R7
      top_bit2_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq2[s] |-> (($past(pend_flat[WORD_W-1:0] & mask_all[s][0]) >> lvl2[s]) == 1));
      // R7
      top_bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq3[s] |-> (($past(pend_flat[2*WORD_W-1:WORD_W] & mask_all[s][1]) >> lvl3[s]) == 1));
   end
endmodule

bind irqp_hub irqp_hub_chk #(.WORD_W(WORD_W), .SYS_RSV(SYS_RSV)) i_chk (
   .clk(clk_i), .rst_n(rst_ni), .bus_we(bus_we_i), .bus_addr(bus_addr_i),
   .bus_wdata(bus_wdata_i), .msg_vld(msg_vld_i), .msg_lvl(msg_lvl_i),
   .ipi_rsch(ipi_rsch_i), .ipi_call(ipi_call_i), .pend_flat(pend_w),
   .mask_all(mask_all), .irq2(irq_ln2_o), .irq3(irq_ln3_o),
   .lvl2(lvl_ln2_o), .lvl3(lvl_ln3_o)
);

// File: tb/test_irqp_hub.sv
module test_irqp_hub;
   localparam int W = 8;
   localparam int LW = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [2:0]    addr = '0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic          mvld = 1'b0;
   logic [LW-1:0] mlvl = '0;
   logic [1:0]    rsch = '0, call = '0;
   logic [1:0]    irq2, irq3;
   logic [1:0][IW-1:0] lvl2, lvl3;

   int n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   irqp_hub #(.WORD_W(W), .SYS_RSV(6), .RSCH_BASE(2), .CALL_BASE(4)) i_irqp_hub (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .msg_vld_i(mvld),
      .msg_lvl_i(mlvl), .ipi_rsch_i(rsch), .ipi_call_i(call),
      .irq_ln2_o(irq2), .irq_ln3_o(irq3), .lvl_ln2_o(lvl2), .lvl_ln3_o(lvl3)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int msb8(input int v);
      int r = 0;
      for (int i = 0; i < W; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      we = 1'b1; addr = 3'(a); wdata = W'(d);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      we = 1'b0; addr = 3'(a);
      @(negedge clk);
      d = int'(rdata);
   endtask

   task automatic msg(input int l);
      @(negedge clk);
      mvld = 1'b1; mlvl = LW'(l);
      @(negedge clk);
      mvld = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(irq2 == 0 && irq3 == 0, "R1 lines", {irq2, irq3}, 0);
      chk(lvl2 == 0 && lvl3 == 0, "R1 levels", {lvl2, lvl3}, 0);
      chk(rdata == 0, "R1 rdata", rdata, 0);
      for (int a = 0; a < 6; a++) begin
         rd(a, d);
         chk(d == 0, "R1 register", d, 0);
      end

      // R2: mask registers read back
      wr(2, 'hA5); wr(3, 'h3C); wr(4, 'h0F); wr(5, 'hF0);
      rd(2, d); chk(d == 'hA5, "R2 maskA0", d, 'hA5);
      rd(3, d); chk(d == 'h3C, "R2 maskA1", d, 'h3C);
      rd(4, d); chk(d == 'h0F, "R2 maskB0", d, 'h0F);
      rd(5, d); chk(d == 'hF0, "R2 maskB1", d, 'hF0);
      // R10: command addresses read as zero
      rd(6, d); chk(d == 0, "R10 read addr 6", d, 0);
      rd(7, d); chk(d == 0, "R10 read addr 7", d, 0);
      wr(2, 0); wr(3, 0); wr(4, 0); wr(5, 0);

      // R3 R4: sweep every level
      for (int l = 0; l < 2 * W; l++) begin
         int exp;
         msg(l);
         rd(l / W, d);
         exp = (l < 6) ? 0 : (1 << (l % W));
         chk(d == exp, "R4 message set", d, exp);
         wr(6, l);
         rd(l / W, d);
         chk(d == (1 << (l % W)), "R3 bus set", d, 1 << (l % W));
         wr(7, l);
         rd(0, d); chk(d == 0, "R3 clear word0", d, 0);
         rd(1, d); chk(d == 0, "R3 clear word1", d, 0);
      end

      // R5: inter-processor levels
      @(negedge clk); rsch = 2'b01; @(negedge clk); rsch = 2'b00;
      rd(0, d); chk(d == 'h04, "R5 resched A", d, 'h04);
      @(negedge clk); rsch = 2'b10; @(negedge clk); rsch = 2'b00;
      rd(0, d); chk(d == 'h0C, "R5 resched B", d, 'h0C);
      @(negedge clk); call = 2'b01; @(negedge clk); call = 2'b00;
      rd(0, d); chk(d == 'h1C, "R5 call A", d, 'h1C);
      @(negedge clk); call = 2'b10; @(negedge clk); call = 2'b00;
      rd(0, d); chk(d == 'h3C, "R5 call B", d, 'h3C);

      // R10: writes to pending addresses ignored
      wr(0, 'hFF); wr(1, 'hFF);
      rd(0, d); chk(d == 'h3C, "R10 pend0 write ignored", d, 'h3C);
      rd(1, d); chk(d == 0, "R10 pend1 write ignored", d, 0);
      for (int l = 2; l < 6; l++) wr(7, l);

      // R6: set beats clear on level 9
      wr(6, 9);
      @(negedge clk);
      mvld = 1'b1; mlvl = 4'd9; we = 1'b1; addr = 3'd7; wdata = 8'd9;
      @(negedge clk);
      mvld = 1'b0; we = 1'b0;
      rd(1, d); chk(d == 'h02, "R6 set wins", d, 'h02);
      wr(7, 9);
      rd(1, d); chk(d == 0, "R6 later clear", d, 0);

      // R7 R8 R9: all word0 mask patterns against a full word0
      for (int l = 0; l < W; l++) wr(6, l);
      for (int m = 0; m < 256; m++) begin
         int mb = (~m) & 'hFF;
         wr(2, m); wr(4, mb);
         @(negedge clk);
         chk(irq2[0] == (m != 0), "R7 slice A line2", irq2[0], m != 0);
         chk(lvl2[0] == msb8(m), "R8 slice A level2", lvl2[0], msb8(m));
         chk(irq2[1] == (mb != 0), "R9 slice B line2", irq2[1], mb != 0);
         chk(lvl2[1] == msb8(mb), "R9 slice B level2", lvl2[1], msb8(mb));
         chk(irq3 == 0, "R9 word0 off line3", irq3, 0);
      end
      wr(2, 0); wr(4, 0);
      for (int l = 0; l < W; l++) wr(7, l);

      // R7 R8: word1 fill and drain
      wr(3, 'hFF); wr(5, 'h0F);
      for (int b = 0; b < W; b++) begin
         wr(6, W + b);
         @(negedge clk);
         chk(irq3[0] && lvl3[0] == b, "R8 fill slice A", lvl3[0], b);
         chk(irq3[1] && lvl3[1] == ((b < 4) ? b : 3), "R8 fill slice B", lvl3[1], (b < 4) ? b : 3);
         chk(irq2 == 0, "R9 word1 off line2", irq2, 0);
      end
      for (int b = W - 1; b > 0; b--) begin
         wr(7, W + b);
         @(negedge clk);
         chk(lvl3[0] == b - 1, "R8 drain slice A", lvl3[0], b - 1);
         chk(irq3[1] == 1'b1, "R7 drain slice B", irq3[1], 1);
      end
      wr(7, W);
      chk(irq3[0] == 1'b1, "R7 line held one cycle", irq3[0], 1);
      @(negedge clk);
      chk(irq3 == 0, "R7 line drops", irq3, 0);
      chk(lvl3 == 0, "R8 level idle", lvl3, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule